// File: doc/BRIEF.md
# I2C Slave Time-of-Day Register File

This block is a bus slave on a two-wire serial bus (I2C). Behind it sits a file of eight byte registers. Three of them are live time-of-day counters for seconds, minutes and hours, kept as two-digit BCD. The counters advance on a one-cycle 1 Hz strobe that is generated elsewhere from a 32.768 kHz source. The other five registers are plain byte storage.

Both bus lines are open drain. The block sees each line through an input and could pull it low through an output enable; it never pulls the clock line. Both inputs are synchronized and glitch-filtered in the system clock domain before any edge is decoded. A master addresses the block, writes a register pointer and optionally data bytes. It may then issue a repeated start and read bytes out sequentially from the pointer. The pointer advances after every data byte and wraps within the file.

The bus side is one state machine with seven states:
- `ST_IDLE`: waiting for a start.
- `ST_ADDR`: shifting in the address byte.
- `ST_ADDR_ACK`: acknowledging a matching address.
- `ST_WR_BYTE`: shifting in a written byte.
- `ST_WR_ACK`: acknowledging a written byte.
- `ST_RD_BYTE`: shifting out a read byte.
- `ST_RD_ACK`: sampling the master's acknowledge.

The transitions are:
- Start, from any state, goes to `ST_ADDR`.
- Stop, from any state, goes to `ST_IDLE`.
- `ST_ADDR` goes to `ST_ADDR_ACK` after eight bits on a match, and to `ST_IDLE` on a miss.
- `ST_ADDR_ACK` goes to `ST_RD_BYTE` when the read/write bit is 1, and to `ST_WR_BYTE` when it is 0.
- `ST_WR_BYTE` goes to `ST_WR_ACK` after eight bits.
- `ST_WR_ACK` goes back to `ST_WR_BYTE`.
- `ST_RD_BYTE` goes to `ST_RD_ACK` after eight bits.
- `ST_RD_ACK` goes to `ST_RD_BYTE` on an ACK, and to `ST_IDLE` on a NACK.

Every transition except start and stop happens on a filtered falling edge of SCL.

Top module: `i2c_bcd_rtc`

## Requirements
- R1: `scl_oe` is always 0. After reset `sda_oe` is 0 and all eight registers read as 0x00. `sda_oe`=1 means the block pulls SDA low.
- R2: The block responds to the 7-bit address formed as six fixed bits 101000 followed by `addr_sel` as the LSB. Address bit 0 of the first byte is 1 for a read and 0 for a write. A matching address is acknowledged by pulling SDA low for the ninth clock. A non-matching address gets no acknowledge, and the bytes that follow it up to the next start change no register.
- R3: In a write transfer, the first data byte loads the pointer from its low 3 bits. Every later byte is stored at the pointer. Each of these bytes is acknowledged.
- R4: The pointer advances by one after each stored or read data byte and wraps from 7 to 0.
- R5: In a read transfer the block sends the register at the pointer MSB first. It changes `sda_oe` only while SCL is low.
- R6: An ACK from the master after a read byte makes the block send the next register. A NACK ends the transfer, and `sda_oe` is 0 before the next start.
- R7: A repeated start keeps the pointer, so a read right after a pointer write returns data from that pointer. A read address with no preceding pointer write continues from the current pointer.
- R8: A stop condition returns the block to idle with SDA released, and the pointer is kept.
- R9: Register 2 holds seconds, register 3 minutes and register 4 hours, each as packed BCD with the tens digit in bits 7:4. Writing one loads that counter, and reading returns its live value.
- R10: Each 1 Hz strobe advances seconds. x9 carries to the next tens digit. Seconds 59 rolls to 00 and advances minutes, minutes 59 rolls to 00 and advances hours, and hours 23 rolls to 00.
- R11: When a bus write to a time register lands in the same cycle as a strobe, the written value is kept and that strobe is dropped.
- R12: Registers 0, 1, 5, 6 and 7 return the last byte written to them.
- R13: A pulse on SDA shorter than 3 system clocks while SCL is high is ignored: it is neither a start nor a stop, and the byte in flight is received intact.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled level of the SCL line |
| sda_i | input | 1 | Sampled level of the SDA line |
| addr_sel | input | 1 | LSB of the slave address |
| tick_1hz | input | 1 | One-cycle strobe once per second |
| scl_oe | output | 1 | Pull SCL low (held at 0) |
| sda_oe | output | 1 | Pull SDA low |

## Verification
The bus write that commits a byte into the seconds register and the 1 Hz strobe can land in the same system clock cycle. The bench provokes this by writing 0x30 over a seconds value of 0x10 while it moves a single strobe, one clock at a time, across a window around the SCL falling edge that ends the data byte. Each result must be 0x30 or 0x31, and never 0x11, which would mean the write was lost. Across the sweep the results must change from 0x30 to 0x31 only once, and both values must appear.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WR_BYTE,
        ST_WR_ACK,
        ST_RD_BYTE,
        ST_RD_ACK
    } bus_state_t;

    typedef logic [7:0] bcd_t;

    localparam int IDX_SEC = 2;
    localparam int IDX_MIN = 3;
    localparam int IDX_HR  = 4;

    localparam bcd_t SEC_MAX = 8'h59;
    localparam bcd_t MIN_MAX = 8'h59;
    localparam bcd_t HR_MAX  = 8'h23;

    // advance a packed BCD value, wrapping to zero after lim
    function automatic bcd_t bcd_step(input bcd_t v, input bcd_t lim);
        if (v == lim)
            return 8'h00;
        else if (v[3:0] == 4'd9)
            return {v[7:4] + 4'd1, 4'd0};
        else
            return v + 8'd1;
    endfunction

endpackage

// File: rtl/rtc_line_filter.sv
module rtc_line_filter #(
    parameter int SYNC_LEN = 2,
    parameter int FILT_LEN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic dout
);

    logic [SYNC_LEN-1:0] sync_q;
    logic [FILT_LEN-1:0] hist_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sync_q <= '1;
            hist_q <= '1;
            dout   <= 1'b1;
        end else begin
            sync_q <= {sync_q[SYNC_LEN-2:0], din};
            hist_q <= {hist_q[FILT_LEN-2:0], sync_q[SYNC_LEN-1]};
            if (&hist_q)
                dout <= 1'b1;
            else if (~|hist_q)
                dout <= 1'b0;
        end
    end

endmodule

// File: rtl/rtc_time_keeper.sv
module rtc_time_keeper
    import rtc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic wr_sec,
    input  logic wr_min,
    input  logic wr_hr,
    input  bcd_t wr_data,
    output bcd_t sec_q,
    output bcd_t min_q,
    output bcd_t hr_q
);

    logic any_wr;
    logic carry_s;
    logic carry_m;

    assign any_wr  = wr_sec | wr_min | wr_hr;
    assign carry_s = (sec_q == SEC_MAX);
    assign carry_m = carry_s && (min_q == MIN_MAX);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sec_q <= '0;
            min_q <= '0;
            hr_q  <= '0;
        end else if (any_wr) begin
            if (wr_sec) sec_q <= wr_data;
            if (wr_min) min_q <= wr_data;
            if (wr_hr)  hr_q  <= wr_data;
        end else if (tick) begin
            sec_q <= bcd_step(sec_q, SEC_MAX);
            if (carry_s) min_q <= bcd_step(min_q, MIN_MAX);
            if (carry_m) hr_q  <= bcd_step(hr_q, HR_MAX);
        end
    end

    // R10
    sec_adv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !any_wr) |=> (sec_q != $past(sec_q)));

    // R10
    min_roll_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !any_wr && sec_q == 8'h59 && min_q == 8'h59) |=> (sec_q == 8'h00 && min_q == 8'h00));

    // R11
    wr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_sec |=> (sec_q == $past(wr_data)));

endmodule

// File: rtl/i2c_bcd_rtc.sv
module i2c_bcd_rtc
    import rtc_pkg::*;
#(
    parameter int         NUM_REGS    = 8,
    parameter int         FILT_LEN    = 3,
    parameter logic [5:0] DEV_ADDR_HI = 6'b101000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    input  logic addr_sel,
    input  logic tick_1hz,
    output logic scl_oe,
    output logic sda_oe
);

    localparam int PTR_W = $clog2(NUM_REGS);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(NUM_REGS - 1);

    // line conditioning
    logic [1:0] raw_lines;
    logic [1:0] filt_lines;
    assign raw_lines = {sda_i, scl_i};

    for (genvar li = 0; li < 2; li++) begin : g_filt
        rtc_line_filter #(.SYNC_LEN(2), .FILT_LEN(FILT_LEN)) i_filt (
            .clk  (clk),
            .rst_n(rst_n),
            .din  (raw_lines[li]),
            .dout (filt_lines[li])
        );
    end

    logic scl_f, sda_f, scl_d, sda_d;
    assign scl_f = filt_lines[0];
    assign sda_f = filt_lines[1];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_d <= 1'b1;
            sda_d <= 1'b1;
        end else begin
            scl_d <= scl_f;
            sda_d <= sda_f;
        end
    end

    logic scl_rise, scl_fall, start_det, stop_det;
    assign scl_rise  = scl_f & ~scl_d;
    assign scl_fall  = ~scl_f & scl_d;
    assign start_det = scl_f & scl_d & sda_d & ~sda_f;
    assign stop_det  = scl_f & scl_d & ~sda_d & sda_f;

    // protocol state
    bus_state_t       state, state_nx;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic [7:0]       txreg;
    logic [PTR_W-1:0] ptr;
    logic             rw_bit;
    logic             first_wr;
    logic             mst_ack;

    logic             addr_hit;
    logic [PTR_W-1:0] ptr_next;
    logic [7:0]       rd_data;
    logic             wr_fire;

    assign addr_hit = (shreg[7:1] == {DEV_ADDR_HI, addr_sel});
    assign ptr_next = (ptr == PTR_LAST) ? '0 : ptr + PTR_W'(1);
    assign wr_fire  = (state == ST_WR_BYTE) && scl_fall && (bit_cnt == 4'd8) && !first_wr;

    // next-state logic
    always_comb begin
        state_nx = state;
        if (stop_det)
            state_nx = ST_IDLE;
        else if (start_det)
            state_nx = ST_ADDR;
        else begin
            unique case (state)
                ST_IDLE:     state_nx = ST_IDLE;
                ST_ADDR:     if (scl_fall && bit_cnt == 4'd8)
                                 state_nx = addr_hit ? ST_ADDR_ACK : ST_IDLE;
                ST_ADDR_ACK: if (scl_fall)
                                 state_nx = rw_bit ? ST_RD_BYTE : ST_WR_BYTE;
                ST_WR_BYTE:  if (scl_fall && bit_cnt == 4'd8)
                                 state_nx = ST_WR_ACK;
                ST_WR_ACK:   if (scl_fall)
                                 state_nx = ST_WR_BYTE;
                ST_RD_BYTE:  if (scl_fall && bit_cnt == 4'd7)
                                 state_nx = ST_RD_ACK;
                ST_RD_ACK:   if (scl_fall)
                                 state_nx = mst_ack ? ST_RD_BYTE : ST_IDLE;
                default:     state_nx = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            shreg    <= '0;
            txreg    <= '0;
            ptr      <= '0;
            rw_bit   <= 1'b0;
            first_wr <= 1'b0;
            mst_ack  <= 1'b0;
        end else if (start_det || stop_det) begin
            bit_cnt <= '0;
        end else begin
            unique case (state)
                ST_ADDR: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_f};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        rw_bit  <= shreg[0];
                        bit_cnt <= '0;
                    end
                end
                ST_ADDR_ACK: begin
                    if (scl_fall) begin
                        bit_cnt  <= '0;
                        first_wr <= 1'b1;
                        if (rw_bit) txreg <= rd_data;
                    end
                end
                ST_WR_BYTE: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_f};
                        bit_cnt <= bit_cnt + 4'd1;
                    end else if (scl_fall && bit_cnt == 4'd8) begin
                        if (first_wr) begin
                            ptr      <= shreg[PTR_W-1:0];
                            first_wr <= 1'b0;
                        end else begin
                            ptr <= ptr_next;
                        end
                    end
                end
                ST_WR_ACK: begin
                    if (scl_fall) bit_cnt <= '0;
                end
                ST_RD_BYTE: begin
                    if (scl_fall) begin
                        if (bit_cnt == 4'd7) begin
                            ptr <= ptr_next;
                        end else begin
                            txreg   <= {txreg[6:0], 1'b0};
                            bit_cnt <= bit_cnt + 4'd1;
                        end
                    end
                end
                ST_RD_ACK: begin
                    if (scl_rise) mst_ack <= ~sda_f;
                    else if (scl_fall) begin
                        bit_cnt <= '0;
                        if (mst_ack) txreg <= rd_data;
                    end
                end
                default: ;
            endcase
        end
    end

    // register storage
    logic [7:0] gp_q [NUM_REGS];
    bcd_t       sec_q, min_q, hr_q;

    for (genvar ri = 0; ri < NUM_REGS; ri++) begin : g_reg
        if (ri == IDX_SEC || ri == IDX_MIN || ri == IDX_HR) begin : g_time_slot
            assign gp_q[ri] = 8'h00;
        end else begin : g_plain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    gp_q[ri] <= '0;
                else if (wr_fire && ptr == PTR_W'(ri))
                    gp_q[ri] <= shreg;
            end
        end
    end

    rtc_time_keeper i_keeper (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_1hz),
        .wr_sec (wr_fire && ptr == PTR_W'(IDX_SEC)),
        .wr_min (wr_fire && ptr == PTR_W'(IDX_MIN)),
        .wr_hr  (wr_fire && ptr == PTR_W'(IDX_HR)),
        .wr_data(shreg),
        .sec_q  (sec_q),
        .min_q  (min_q),
        .hr_q   (hr_q)
    );

    always_comb begin
        if (ptr == PTR_W'(IDX_SEC))      rd_data = sec_q;
        else if (ptr == PTR_W'(IDX_MIN)) rd_data = min_q;
        else if (ptr == PTR_W'(IDX_HR))  rd_data = hr_q;
        else                             rd_data = gp_q[ptr];
    end

    // outputs
    assign scl_oe = 1'b0;

    always_comb begin
        unique case (state)
            ST_ADDR_ACK: sda_oe = 1'b1;
            ST_WR_ACK:   sda_oe = 1'b1;
            ST_RD_BYTE:  sda_oe = ~txreg[7];
            default:     sda_oe = 1'b0;
        endcase
    end

    // R5
    oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sda_oe != $past(sda_oe)) |-> !scl_f);

    // R2
    addr_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ADDR && scl_fall && bit_cnt == 4'd8 && !addr_hit) |=> !sda_oe);

endmodule

// File: tb/test_i2c_bcd_rtc.sv
module test_i2c_bcd_rtc;

    localparam int H = 16;
    localparam bit [6:0] DEV0 = 7'h50;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic addr_sel = 1'b0;
    logic tick_1hz = 1'b0;
    logic m_scl_low = 1'b0;
    logic m_sda_low = 1'b0;
    logic scl_oe, sda_oe;
    logic scl_i, sda_i;

    assign scl_i = ~(m_scl_low | scl_oe);
    assign sda_i = ~(m_sda_low | sda_oe);

    always #2 clk = ~clk;

    i2c_bcd_rtc i_i2c_bcd_rtc (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .addr_sel(addr_sel), .tick_1hz(tick_1hz),
        .scl_oe(scl_oe), .sda_oe(sda_oe)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit [7:0] mdl [8];
    bit [7:0] rbuf [16];
    bit [7:0] wbuf [8];
    bit mark_flag = 1'b0;
    int oe_viol = 0;
    logic prev_oe = 1'b0;

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // R5 monitor: sda_oe must not move while SCL is high
    always @(negedge clk) begin
        if (rst_n && !m_scl_low && sda_oe !== prev_oe) oe_viol++;
        prev_oe <= sda_oe;
    end

    function automatic bit [7:0] bstep(bit [7:0] v, bit [7:0] lim);
        if (v == lim) return 8'h00;
        if (v[3:0] == 4'd9) return {v[7:4] + 4'd1, 4'd0};
        return v + 8'd1;
    endfunction

    function automatic bit [7:0] to_bcd(int v);
        return {4'(v / 10), 4'(v % 10)};
    endfunction

    task automatic hw(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic model_tick();
        if (mdl[2] == 8'h59) begin
            mdl[2] = 8'h00;
            if (mdl[3] == 8'h59) begin
                mdl[3] = 8'h00;
                mdl[4] = bstep(mdl[4], 8'h23);
            end else mdl[3] = bstep(mdl[3], 8'h59);
        end else mdl[2] = bstep(mdl[2], 8'h59);
    endtask

    task automatic pulse_tick();
        @(negedge clk) tick_1hz = 1'b1;
        @(negedge clk) tick_1hz = 1'b0;
        model_tick();
    endtask

    task automatic i2c_start();
        if (m_scl_low) begin
            m_sda_low = 1'b0; hw(H/2);
            m_scl_low = 1'b0; hw(H/2);
        end
        m_sda_low = 1'b1; hw(H/2);
        m_scl_low = 1'b1; hw(H/2);
    endtask

    task automatic i2c_stop();
        m_sda_low = 1'b1; hw(H/2);
        m_scl_low = 1'b0; hw(H/2);
        m_sda_low = 1'b0; hw(H);
    endtask

    task automatic send_bit(bit b, bit glitch, bit mark);
        m_sda_low = ~b; hw(H/2);
        m_scl_low = 1'b0;
        if (glitch) begin
            hw(H/2); m_sda_low = 1'b1; hw(1); m_sda_low = 1'b0; hw(H/2 - 1);
        end else hw(H);
        m_scl_low = 1'b1;
        if (mark) mark_flag = 1'b1;
        hw(H/2);
    endtask

    task automatic recv_bit(output bit b);
        m_sda_low = 1'b0; hw(H/2);
        m_scl_low = 1'b0; hw(H/2);
        b = sda_i; hw(H/2);
        m_scl_low = 1'b1; hw(H/2);
    endtask

    task automatic write_byte(bit [7:0] b, int glitch_pos, bit mark, output bit ack);
        bit a;
        for (int i = 7; i >= 0; i--) send_bit(b[i], i == glitch_pos, mark && i == 0);
        recv_bit(a);
        ack = ~a;
    endtask

    task automatic read_byte(bit ack, output bit [7:0] v);
        bit x;
        for (int i = 7; i >= 0; i--) begin recv_bit(x); v[i] = x; end
        send_bit(~ack, 1'b0, 1'b0);
    endtask

    // write n bytes from wbuf starting at register p, returns 1 if every byte acked
    task automatic wr_at(bit [6:0] dev, bit [7:0] p, int n, output bit all_ack);
        bit a;
        all_ack = 1'b1;
        i2c_start();
        write_byte({dev, 1'b0}, -1, 1'b0, a); all_ack &= a;
        write_byte(p, -1, 1'b0, a); all_ack &= a;
        for (int i = 0; i < n; i++) begin
            write_byte(wbuf[i], -1, 1'b0, a); all_ack &= a;
        end
        i2c_stop();
    endtask

    task automatic rd_at(bit [6:0] dev, bit [7:0] p, bit set_ptr, int n, output bit all_ack);
        bit a;
        all_ack = 1'b1;
        i2c_start();
        if (set_ptr) begin
            write_byte({dev, 1'b0}, -1, 1'b0, a); all_ack &= a;
            write_byte(p, -1, 1'b0, a); all_ack &= a;
            i2c_start();
        end
        write_byte({dev, 1'b1}, -1, 1'b0, a); all_ack &= a;
        for (int i = 0; i < n; i++) read_byte(i != n - 1, rbuf[i]);
        i2c_stop();
    endtask

    task automatic model_write(bit [7:0] p, int n);
        for (int i = 0; i < n; i++) mdl[(p + i) & 7] = wbuf[i];
    endtask

    task automatic check_read(string tag, bit [7:0] p, int n);
        for (int i = 0; i < n; i++) check(tag, rbuf[i], mdl[(p + i) & 7]);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        bit ok;
        bit seen_hi, seen_lo, mono;
        int res;
        void'($urandom(32'd4242));
        for (int i = 0; i < 8; i++) mdl[i] = 8'h00;
        hw(5);
        rst_n = 1'b1;
        hw(20);

        // R1 reset state
        check("R1 scl_oe", scl_oe, 0);
        check("R1 sda_oe", sda_oe, 0);
        rd_at(DEV0, 8'h00, 1'b1, 8, ok);
        check("R1 ack", ok, 1);
        check_read("R1 reset regs", 8'h00, 8);

        // R3 R4 R12: write across the wrap 6,7,0,1
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'hE1; wbuf[3] = 8'h7F;
        wr_at(DEV0, 8'h06, 4, ok);
        check("R3 ack", ok, 1);
        model_write(8'h06, 4);
        rd_at(DEV0, 8'h06, 1'b1, 4, ok);
        check_read("R4 wrap R12", 8'h06, 4);
        // R3 upper pointer bits ignored: 0xF9 selects register 1
        wbuf[0] = 8'h42;
        wr_at(DEV0, 8'hF9, 1, ok);
        model_write(8'h01, 1);
        rd_at(DEV0, 8'h01, 1'b1, 1, ok);
        check("R3 ptr low bits", rbuf[0], 8'h42);

        // R7 R8: read without pointer write continues at current pointer (now 2)
        rd_at(DEV0, 8'h00, 1'b0, 2, ok);
        check("R7 cur ptr ack", ok, 1);
        check_read("R7 cur ptr", 8'h02, 2);
        check("R8 released", sda_oe, 0);

        // R2 address mismatch: no ack, nothing stored
        begin
            bit a;
            i2c_start();
            write_byte({7'h52, 1'b0}, -1, 1'b0, a);
            check("R2 miss nack", a, 0);
            write_byte(8'h00, -1, 1'b0, a);
            write_byte(8'h99, -1, 1'b0, a);
            i2c_stop();
        end
        rd_at(DEV0, 8'h00, 1'b1, 1, ok);
        check("R2 miss no store", rbuf[0], mdl[0]);

        // R2 addr_sel picks the LSB
        addr_sel = 1'b1; hw(4);
        begin
            bit a;
            i2c_start(); write_byte({7'h50, 1'b1}, -1, 1'b0, a); i2c_stop();
            check("R2 sel1 old addr", a, 0);
        end
        rd_at(7'h51, 8'h07, 1'b1, 1, ok);
        check("R2 sel1 ack", ok, 1);
        check("R2 sel1 data", rbuf[0], mdl[7]);
        addr_sel = 1'b0; hw(4);

        // R6 NACK releases SDA
        begin
            bit a; bit [7:0] v;
            i2c_start(); write_byte({DEV0, 1'b1}, -1, 1'b0, a);
            read_byte(1'b0, v);
            check("R6 nack release", sda_oe, 0);
            i2c_stop();
        end

        // R9 R10 rollover chain
        wbuf[0] = 8'h59; wbuf[1] = 8'h59; wbuf[2] = 8'h23;
        wr_at(DEV0, 8'h02, 3, ok);
        model_write(8'h02, 3);
        pulse_tick();
        rd_at(DEV0, 8'h02, 1'b1, 3, ok);
        check("R10 roll sec", rbuf[0], 8'h00);
        check("R10 roll min", rbuf[1], 8'h00);
        check("R10 roll hr", rbuf[2], 8'h00);
        wbuf[0] = 8'h09; wbuf[1] = 8'h19; wbuf[2] = 8'h09;
        wr_at(DEV0, 8'h02, 3, ok);
        model_write(8'h02, 3);
        pulse_tick();
        rd_at(DEV0, 8'h02, 1'b1, 3, ok);
        check("R10 digit carry", rbuf[0], 8'h10);
        check_read("R9 live", 8'h02, 3);

        // R13 glitch on SDA while SCL high
        begin
            bit a, all;
            all = 1'b1;
            i2c_start();
            write_byte({DEV0, 1'b0}, -1, 1'b0, a); all &= a;
            write_byte(8'h05, -1, 1'b0, a); all &= a;
            write_byte(8'hFF, 3, 1'b0, a); all &= a;
            i2c_stop();
            check("R13 ack", all, 1);
            mdl[5] = 8'hFF;
        end
        rd_at(DEV0, 8'h05, 1'b1, 1, ok);
        check("R13 byte intact", rbuf[0], 8'hFF);

        // R11 write/tick collision sweep
        seen_hi = 1'b0; seen_lo = 1'b0; mono = 1'b1;
        for (int k = 0; k < 14; k++) begin
            bit a;
            wbuf[0] = 8'h10;
            wr_at(DEV0, 8'h02, 1, ok);
            mark_flag = 1'b0;
            fork
                begin
                    i2c_start();
                    write_byte({DEV0, 1'b0}, -1, 1'b0, a);
                    write_byte(8'h02, -1, 1'b0, a);
                    write_byte(8'h30, -1, 1'b1, a);
                    i2c_stop();
                end
                begin
                    wait (mark_flag);
                    hw(k);
                    @(negedge clk) tick_1hz = 1'b1;
                    @(negedge clk) tick_1hz = 1'b0;
                end
            join
            rd_at(DEV0, 8'h02, 1'b1, 1, ok);
            res = rbuf[0];
            if (res == 8'h31) seen_hi = 1'b1;
            else if (res == 8'h30) begin seen_lo = 1'b1; if (seen_hi) mono = 1'b0; end
            check("R11 value set", (res == 8'h30 || res == 8'h31), 1);
            mdl[2] = rbuf[0];
        end
        check("R11 monotone", mono, 1);
        check("R11 both seen", seen_hi && seen_lo, 1);

        // random traffic: R3 R4 R5 R9 R10 R12
        for (int it = 0; it < 14; it++) begin
            int nt, p, n, q, m;
            nt = $urandom_range(0, 70);
            for (int t = 0; t < nt; t++) pulse_tick();
            p = $urandom_range(0, 7);
            n = $urandom_range(1, 4);
            for (int i = 0; i < n; i++) begin
                int idx;
                idx = (p + i) & 7;
                if (idx == 2 || idx == 3) wbuf[i] = to_bcd($urandom_range(0, 59));
                else if (idx == 4) wbuf[i] = to_bcd($urandom_range(0, 23));
                else wbuf[i] = 8'($urandom_range(0, 255));
            end
            wr_at(DEV0, 8'(p), n, ok);
            check("R3 rand ack", ok, 1);
            model_write(8'(p), n);
            q = $urandom_range(0, 7);
            m = $urandom_range(1, 8);
            rd_at(DEV0, 8'(q), 1'b1, m, ok);
            check_read("R5 rand read", 8'(q), m);
        end

        check("R5 oe only while SCL low", oe_viol, 0);
        check("R1 scl_oe end", scl_oe, 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule